// File: doc/BRIEF.md
# Serial Switch-Status Slave Port

This block is the serial slave front end of a switch monitor. While the active-low chip select is held low, the block exchanges one 16-bit frame with a serial master. At the start of the frame it freezes a picture of the debounced switch inputs, the operating mode and the interrupt state. It sends that picture out on the serial output, most significant bit first. At the same time it collects a 16-bit command word from the serial input. The command word is moved into the command register only when chip select rises, and only if exactly 16 rising clock edges arrived during the frame.

All serial pins are first brought into the system clock domain and then handled by edge detection. The serial output is given as a data bit plus an output enable; a pad cell outside the block builds the high-impedance state from these two signals. The active-low interrupt output asserts when the switches differ from the last reported picture. The end of a frame releases it.

A serial frame cannot be stalled, so the block has no valid/ready path. Back-pressure does not apply: the master sets the pace, and the system clock must run at least eight times faster than the serial clock.

Top module: `spi_switch_slave`

## Requirements
- R1: After reset the command register is 0, the output enable is 0 and the interrupt output is 1.
- R2: The serial output enable is 1 while chip select is low, and it returns to 0 after chip select rises.
- R3: The outgoing frame is captured as chip select falls, and its bit 15 is on the serial output before the first clock edge. Bit 15 holds the pending interrupt state (1 = pending). Bit 14 holds the mode input. Bits 13:0 hold the switch inputs, where a closed switch reads 1 and an open switch reads 0.
- R4: Each falling serial clock edge inside a frame presents the next lower bit on the serial output. The serial output does not change at any other time within the frame.
- R5: The serial input is sampled on rising serial clock edges, MSB first. After exactly 16 rising edges, the command register takes the received word when chip select rises.
- R6: If a frame has any number of rising edges other than 16, the command register keeps its previous value.
- R7: The command register never changes while a frame is in progress.
- R8: Outside a frame, the interrupt output goes low when the switch inputs differ from the switch values of the last frame.
- R9: In the cycle after chip select rises, the interrupt output is 1.
- R10: A switch change during a frame does not alter the bits being shifted out, and it does not assert the interrupt during that frame. The change asserts the interrupt after chip select rises.
- R11: While chip select is high, activity on the serial clock and serial input has no effect on the command register or on the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial command data in |
| sw_closed_i | input | 14 | Debounced switch states, 1 = closed |
| mode_i | input | 1 | Current operating mode, reported in the frame |
| miso_o | output | 1 | Serial status data out |
| miso_oe_o | output | 1 | Output enable for the serial output pad |
| int_n_o | output | 1 | Active-low interrupt |
| cmd_o | output | 16 | Active command register |

## Verification
The properties assume that chip select changes only while the serial clock is low. They also assume that each serial clock level and each chip-select level lasts several system clocks, so that no two synchronised edges land in the same cycle. The bench holds the serial clock at four system clocks per level. It changes the serial input two cycles before each rising edge and moves chip select only with the serial clock low. Switch inputs change either between frames or while the serial clock is high.

// File: rtl/spi_sw_pkg.sv
package spi_sw_pkg;
  localparam int unsigned DEF_FRAME_W = 16;
  localparam int unsigned DEF_SYNC_N  = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic edge_t edge_of(input logic now_v, input logic old_v);
    edge_t e;
    e.rise = now_v & ~old_v;
    e.fall = ~now_v & old_v;
    return e;
  endfunction
endpackage

// File: rtl/spi_sw_sync.sv
module spi_sw_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_V[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_sw_rx.sv
module spi_sw_rx #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               active_i,
  input  logic               bit_rise_i,
  input  logic               mosi_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               word_ok_o
);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      cnt_q   <= '0;
    end else if (active_i && bit_rise_i) begin
      shift_q <= {shift_q[FRAME_W-2:0], mosi_i};
      if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o    = shift_q;
  assign word_ok_o = (cnt_q == FULL);
endmodule

// File: rtl/spi_sw_tx.sv
module spi_sw_tx #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               stop_i,
  input  logic               active_i,
  input  logic               bit_fall_i,
  input  logic [FRAME_W-1:0] snap_i,
  output logic               miso_o,
  output logic               oe_o
);
  logic [FRAME_W-1:0] shift_q;
  logic               oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      oe_q    <= 1'b0;
    end else if (load_i) begin
      shift_q <= snap_i;
      oe_q    <= 1'b1;
    end else if (stop_i) begin
      oe_q    <= 1'b0;
    end else if (active_i && bit_fall_i) begin
      shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso_o = shift_q[FRAME_W-1];
  assign oe_o   = oe_q;
endmodule

// File: rtl/spi_sw_irq.sv
module spi_sw_irq #(
  parameter int unsigned SW_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            active_i,
  input  logic [SW_W-1:0] sw_i,
  input  logic            mode_i,
  output logic [SW_W+1:0] snap_o,
  output logic            int_n_o
);
  logic [SW_W-1:0] ref_q;
  logic [SW_W-1:0] held_q;
  logic            pend_q;
  logic            differ;

  assign differ = (sw_i != ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      held_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (start_i) held_q <= sw_i;
      if (stop_i) begin
        ref_q  <= held_q;
        pend_q <= 1'b0;
      end else if (!active_i && differ) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign snap_o  = {pend_q, mode_i, sw_i};
  assign int_n_o = ~pend_q;
endmodule

// File: rtl/spi_switch_slave.sv
module spi_switch_slave #(
  parameter int unsigned FRAME_W = spi_sw_pkg::DEF_FRAME_W,
  parameter int unsigned SYNC_N  = spi_sw_pkg::DEF_SYNC_N,
  localparam int unsigned SW_W   = FRAME_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               csn_i,
  input  logic               mosi_i,
  input  logic [SW_W-1:0]    sw_closed_i,
  input  logic               mode_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  output logic               int_n_o,
  output logic [FRAME_W-1:0] cmd_o
);
  import spi_sw_pkg::*;

  logic [2:0] pins_s;
  logic       sclk_s, csn_s, mosi_s;
  logic       sclk_d, csn_d;
  edge_t      sclk_e, cs_e;
  logic       cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic       frame_active;
  logic [FRAME_W-1:0] rx_word, snap_word, cmd_q;
  logic       word_ok;

  spi_sw_sync #(.W(3), .STAGES(SYNC_N), .RST_V(3'b010)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({mosi_i, csn_i, sclk_i}),
    .sync_o (pins_s)
  );
  assign sclk_s = pins_s[0];
  assign csn_s  = pins_s[1];
  assign mosi_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign sclk_e    = edge_of(sclk_s, sclk_d);
  assign cs_e      = edge_of(csn_s, csn_d);
  assign cs_fall   = cs_e.fall;
  assign cs_rise   = cs_e.rise;
  assign sclk_rise = sclk_e.rise;
  assign sclk_fall = sclk_e.fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_active <= 1'b0;
    else if (cs_fall) frame_active <= 1'b1;
    else if (cs_rise) frame_active <= 1'b0;
  end

  spi_sw_irq #(.SW_W(SW_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (cs_fall),
    .stop_i  (cs_rise),
    .active_i(frame_active),
    .sw_i    (sw_closed_i),
    .mode_i  (mode_i),
    .snap_o  (snap_word),
    .int_n_o (int_n_o)
  );

  spi_sw_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (cs_fall),
    .stop_i    (cs_rise),
    .active_i  (frame_active),
    .bit_fall_i(sclk_fall),
    .snap_i    (snap_word),
    .miso_o    (miso_o),
    .oe_o      (miso_oe_o)
  );

  spi_sw_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (cs_fall),
    .active_i  (frame_active),
    .bit_rise_i(sclk_rise),
    .mosi_i    (mosi_s),
    .word_o    (rx_word),
    .word_ok_o (word_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cmd_q <= '0;
    else if (cs_rise && frame_active && word_ok) cmd_q <= rx_word;
  end
  assign cmd_o = cmd_q;
endmodule

// File: rtl/spi_switch_slave_chk.sv
module spi_switch_slave_chk #(
  parameter int unsigned FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_fall,
  input logic               cs_rise,
  input logic               sclk_fall,
  input logic               frame_active,
  input logic               word_ok,
  input logic               miso_o,
  input logic               miso_oe_o,
  input logic               int_n_o,
  input logic [FRAME_W-1:0] cmd_o
);
  p_oe_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> miso_oe_o);
  p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !miso_oe_o);
  p_miso_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe_o && !sclk_fall && !cs_fall && !cs_rise) |=> $stable(miso_o));
  p_short_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !word_ok) |=> $stable(cmd_o));
  p_cmd_only_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(cmd_o));
  p_int_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> int_n_o);
  p_no_int_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n_o) |-> !$past(frame_active));
endmodule

bind spi_switch_slave spi_switch_slave_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_fall     (cs_fall),
  .cs_rise     (cs_rise),
  .sclk_fall   (sclk_fall),
  .frame_active(frame_active),
  .word_ok     (word_ok),
  .miso_o      (miso_o),
  .miso_oe_o   (miso_oe_o),
  .int_n_o     (int_n_o),
  .cmd_o       (cmd_o)
);

// File: tb/spi_switch_slave_bench.sv
module spi_switch_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, mode = 1'b0;
  logic [13:0] sw = '0;
  logic miso, miso_oe, int_n;
  logic [15:0] cmd;

  int total = 0, bad = 0;
  bit  done = 1'b0;
  logic [15:0] mid_cmd;
  logic        mid_oe;

  always #5 clk = ~clk;

  spi_switch_slave u_spi_switch_slave (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .sw_closed_i(sw), .mode_i(mode), .miso_o(miso), .miso_oe_o(miso_oe),
    .int_n_o(int_n), .cmd_o(cmd)
  );

  // entry: {switches[13:0], mode, command[15:0], rising edges[4:0]}
  localparam logic [35:0] VEC [6] = '{
    {14'h0000, 1'b0, 16'hA5C3, 5'd16},
    {14'h2A55, 1'b1, 16'h1234, 5'd16},
    {14'h2A55, 1'b0, 16'hFFFF, 5'd15},
    {14'h3FFF, 1'b1, 16'h0001, 5'd17},
    {14'h0001, 1'b0, 16'h8000, 5'd16},
    {14'h0001, 1'b1, 16'h0F0F, 5'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] wr, input int n, input bit chg,
                       input logic [13:0] new_sw, output logic [15:0] got);
    got = '0;
    csn = 1'b0;
    wait_clk(4);
    got[15] = miso;
    mid_oe  = miso_oe;
    mid_cmd = cmd;
    for (int i = 0; i < n; i++) begin
      mosi = (i < 16) ? wr[15-i] : 1'b0;
      wait_clk(2);
      sclk = 1'b1;
      wait_clk(4);
      if (i == 7) begin
        mid_cmd = cmd;
        if (chg) sw = new_sw;
      end
      sclk = 1'b0;
      wait_clk(4);
      if (i < 15) got[14-i] = miso;
    end
    mosi = 1'b0;
    wait_clk(2);
    csn = 1'b1;
    wait_clk(4);
  endtask

  function automatic logic [15:0] top_mask(input int n);
    int k = (n + 1 > 16) ? 16 : n + 1;
    return (k >= 16) ? 16'hFFFF : ~(16'hFFFF >> k);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] ref_sw;
    logic [15:0] exp_cmd, got, exp_st;
    logic        exp_irq;
    ref_sw = '0; exp_cmd = '0;
    wait_clk(3);
    chk("R1 cmd", cmd, 16'h0);
    chk("R1 oe", {15'h0, miso_oe}, 16'h0);
    chk("R1 int", {15'h0, int_n}, 16'h1);
    rst_n = 1'b1;
    wait_clk(2);

    for (int v = 0; v < 6; v++) begin
      logic [13:0] vsw;
      logic        vmode;
      logic [15:0] vcmd;
      int          vn;
      vsw = VEC[v][35:22]; vmode = VEC[v][21]; vcmd = VEC[v][20:5]; vn = int'(VEC[v][4:0]);
      sw = vsw; mode = vmode;
      wait_clk(4);
      exp_irq = (vsw != ref_sw);
      chk("R8 int before frame", {15'h0, int_n}, {15'h0, ~exp_irq});
      frame(vcmd, vn, 1'b0, '0, got);
      exp_st = {exp_irq, vmode, vsw};
      chk("R3 R4 status bits", got & top_mask(vn), exp_st & top_mask(vn));
      chk("R2 oe in frame", {15'h0, mid_oe}, 16'h1);
      chk("R7 cmd mid frame", mid_cmd, exp_cmd);
      if (vn == 16) exp_cmd = vcmd;
      chk((vn == 16) ? "R5 cmd applied" : "R6 cmd kept", cmd, exp_cmd);
      chk("R2 oe after frame", {15'h0, miso_oe}, 16'h0);
      chk("R9 int after frame", {15'h0, int_n}, 16'h1);
      ref_sw = vsw;
    end

    // R11: clock and data activity with chip select high
    for (int i = 0; i < 20; i++) begin
      mosi = i[0]; wait_clk(2); sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(2);
      if (i == 10) chk("R11 oe idle", {15'h0, miso_oe}, 16'h0);
    end
    chk("R11 cmd untouched", cmd, exp_cmd);

    // R10: switch change in mid frame
    sw = 14'h0F00; mode = 1'b0;
    wait_clk(4);
    frame(16'h3C3C, 16, 1'b1, 14'h00F0, got);
    chk("R10 bits frozen", got, {1'b1, 1'b0, 14'h0F00});
    chk("R5 cmd after mid change", cmd, 16'h3C3C);
    wait_clk(2);
    chk("R10 int after frame", {15'h0, int_n}, 16'h0);
    frame(16'h0000, 16, 1'b0, '0, got);
    chk("R10 next frame", got, {1'b1, 1'b0, 14'h00F0});
    chk("R9 int released", {15'h0, int_n}, 16'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule